// File: doc/BRIEF.md
# Character Input Port with Interrupt Request

This block places a character-producing input device on a simple word-addressed register bus. The device side presents a character together with a one-cycle strobe. The block latches the character and sets a done flag. Software enables interrupts and sets a per-device priority through a status register. While a character is waiting and interrupts are enabled, the block raises an interrupt request. It drives the device priority and a programmable vector index alongside that request, for use by the processor's interrupt logic.

Software fetches the character by reading the data word, and that read consumes the pending flag. If a second character arrives before the first has been read, the data word is overwritten and an overrun indication is raised. The overrun indication stays set until software reads the status word. Bus reads return data one cycle after the access. All state uses a synchronous active-high reset.

Top module: `char_input_port`

## Requirements
- R1: After reset, the status word reads 0x0000, the data word reads 0x0000, `irq_req` is low, and the vector word and `irq_vector` equal the parameter `VEC_RESET` (default 0x0180).
- R2: A cycle with `char_strobe` high loads `char_in` into the data word and sets the done flag.
- R3: The status word (offset 0) reads as follows: bit 15 is done, bit 14 is interrupt enable, bit 13 is overrun, bits 2:0 are the priority, and all other bits are zero.
- R4: A bus write to offset 0 updates only the enable bit (from `bus_wdata[14]`) and the priority (from `bus_wdata[2:0]`). Done and overrun keep their values.
- R5: A bus read of offset 1 returns the data word and clears done at that clock edge. If `char_strobe` is high in the same cycle, the strobe wins: done stays set and the read returns the previous character.
- R6: A strobe that arrives while done is set (and no data read is in the same cycle) overwrites the data word and sets overrun. A bus read of offset 0 clears overrun, unless a new overrun occurs in that same cycle, in which case overrun stays set.
- R7: `irq_req` is high exactly while done and enable are both set. `irq_prio` always carries the priority field.
- R8: Offset 2 is a read/write vector word, and `irq_vector` always carries its value.
- R9: Writes to offset 1 and offset 3 have no effect, and reads of offset 3 return 0x0000.
- R10: `bus_rdata` is registered. It presents the addressed word in the cycle after a read access and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word offset (0 status, 1 data, 2 vector, 3 unused) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| char_strobe | input | 1 | Device presents a new character |
| char_in | input | 16 | Character from the device |
| irq_req | output | 1 | Interrupt request |
| irq_prio | output | 3 | Device priority sent with the request |
| irq_vector | output | 16 | Interrupt vector table index |

## Verification
The bench targets three collision cases. The first is a character strobe in the same cycle as a data read; a design that let the read win would drop done and lose the new character's interrupt. The second is a strobe during a status read with a character already pending; a design that let the clear win would hide the overrun. The third is a status write while a character waits; a design that wrote bit 15 or bit 13 from the bus would fake or erase a pending character. The bench also checks that the request falls in the cycle after the data read, and that the unused offsets ignore writes.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam int WORD_W = 16;
  localparam int PRIO_W = 3;
  localparam int OFF_W  = 2;

  localparam int BIT_DONE = 15;
  localparam int BIT_IE   = 14;
  localparam int BIT_OVR  = 13;

  typedef enum logic [OFF_W-1:0] {
    OFF_STATUS = 2'd0,
    OFF_DATA   = 2'd1,
    OFF_VECTOR = 2'd2,
    OFF_SPARE  = 2'd3
  } reg_off_e;
endpackage

// File: rtl/cip_bus_decode.sv
module cip_bus_decode
  import cip_pkg::*;
(
  input  logic             sel,
  input  logic             wr,
  input  logic [OFF_W-1:0] addr,
  output logic             rd_en,
  output logic             wr_status,
  output logic             wr_vector,
  output logic             rd_status,
  output logic             rd_data
);
  reg_off_e off;

  always_comb begin
    off       = reg_off_e'(addr);
    rd_en     = sel && !wr;
    wr_status = sel && wr  && (off == OFF_STATUS);
    wr_vector = sel && wr  && (off == OFF_VECTOR);
    rd_status = sel && !wr && (off == OFF_STATUS);
    rd_data   = sel && !wr && (off == OFF_DATA);
  end
endmodule

// File: rtl/cip_status_reg.sv
module cip_status_reg
  import cip_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_status,
  input  logic              wr_ie,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic              rd_status,
  input  logic              rd_data,
  input  logic              strobe,
  output logic              done,
  output logic              ie,
  output logic              ovr,
  output logic [PRIO_W-1:0] prio,
  output logic [WORD_W-1:0] status_word
);
  logic overrun_now;

  assign overrun_now = strobe && done && !rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      ie   <= 1'b0;
      ovr  <= 1'b0;
      prio <= '0;
    end else begin
      if (wr_status) begin
        ie   <= wr_ie;
        prio <= wr_prio;
      end
      if (strobe)       done <= 1'b1;
      else if (rd_data) done <= 1'b0;
      if (overrun_now)    ovr <= 1'b1;
      else if (rd_status) ovr <= 1'b0;
    end
  end

  always_comb begin
    status_word              = '0;
    status_word[BIT_DONE]    = done;
    status_word[BIT_IE]      = ie;
    status_word[BIT_OVR]     = ovr;
    status_word[PRIO_W-1:0]  = prio;
  end

  assert_strobe_sets_done_R2: assert property (@(posedge clk) disable iff (rst)
    strobe |=> done);
  assert_read_clears_done_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !strobe) |=> !done);
  assert_write_keeps_done_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_status && !strobe && !rd_data) |=> $stable(done));
  assert_overrun_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe && done && !rd_data) |=> ovr);
  assert_status_read_clears_ovr_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !(strobe && done)) |=> !ovr);
endmodule

// File: rtl/cip_char_reg.sv
module cip_char_reg
  import cip_pkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_RESET = 16'h0180
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [WORD_W-1:0] char_in,
  input  logic              wr_vector,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] data_q,
  output logic [WORD_W-1:0] vector_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      vector_q <= VEC_RESET;
    end else begin
      if (strobe)    data_q   <= char_in;
      if (wr_vector) vector_q <= wdata;
    end
  end

  assert_char_loads_R2: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (data_q == $past(char_in)));
  assert_vector_write_R8: assert property (@(posedge clk) disable iff (rst)
    wr_vector |=> (vector_q == $past(wdata)));
endmodule

// File: rtl/cip_read_mux.sv
module cip_read_mux
  import cip_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  addr,
  input  logic [WORD_W-1:0] status_word,
  input  logic [WORD_W-1:0] data_word,
  input  logic [WORD_W-1:0] vector_word,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    unique case (reg_off_e'(addr))
      OFF_STATUS: sel_word = status_word;
      OFF_DATA:   sel_word = data_word;
      OFF_VECTOR: sel_word = vector_word;
      default:    sel_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel_word;
  end

  assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/char_input_port.sv
module char_input_port
  import cip_pkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_RESET = 16'h0180
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              char_strobe,
  input  logic [WORD_W-1:0] char_in,
  output logic              irq_req,
  output logic [PRIO_W-1:0] irq_prio,
  output logic [WORD_W-1:0] irq_vector
);
  logic rd_en, wr_status, wr_vector, rd_status, rd_data;
  logic done, ie, ovr;
  logic [PRIO_W-1:0] prio;
  logic [WORD_W-1:0] status_word, data_q, vector_q;

  cip_bus_decode u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .rd_en(rd_en), .wr_status(wr_status), .wr_vector(wr_vector),
    .rd_status(rd_status), .rd_data(rd_data)
  );

  cip_status_reg u_stat (
    .clk(clk), .rst(rst),
    .wr_status(wr_status), .wr_ie(bus_wdata[BIT_IE]), .wr_prio(bus_wdata[PRIO_W-1:0]),
    .rd_status(rd_status), .rd_data(rd_data), .strobe(char_strobe),
    .done(done), .ie(ie), .ovr(ovr), .prio(prio), .status_word(status_word)
  );

  cip_char_reg #(.VEC_RESET(VEC_RESET)) u_chr (
    .clk(clk), .rst(rst), .strobe(char_strobe), .char_in(char_in),
    .wr_vector(wr_vector), .wdata(bus_wdata),
    .data_q(data_q), .vector_q(vector_q)
  );

  cip_read_mux u_rmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(bus_addr),
    .status_word(status_word), .data_word(data_q), .vector_word(vector_q),
    .rdata(bus_rdata)
  );

  assign irq_req    = done && ie;
  assign irq_prio   = prio;
  assign irq_vector = vector_q;

  assert_irq_drops_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !char_strobe) |=> !irq_req);
  assert_irq_follows_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    (char_strobe && ie && !wr_status) |=> irq_req);
endmodule

// File: tb/char_input_port_bench.sv
module char_input_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0, bus_rdata;
  logic        char_strobe = 1'b0;
  logic [15:0] char_in = 16'h0;
  logic        irq_req;
  logic [2:0]  irq_prio;
  logic [15:0] irq_vector;

  int checks = 0, failures = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;

  char_input_port u_char_input_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .char_strobe(char_strobe),
    .char_in(char_in), .irq_req(irq_req), .irq_prio(irq_prio), .irq_vector(irq_vector)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] off, logic [15:0] val);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = off; bus_wdata = val;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] off, output logic [15:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = off;
    @(negedge clk);
    v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic send_char(logic [15:0] c);
    @(negedge clk);
    char_strobe = 1'b1; char_in = c;
    @(negedge clk);
    char_strobe = 1'b0;
  endtask

  task automatic read_with_strobe(logic [1:0] off, logic [15:0] c, output logic [15:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = off;
    char_strobe = 1'b1; char_in = c;
    @(negedge clk);
    v = bus_rdata;
    bus_sel = 1'b0; char_strobe = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 irq_req", {15'd0, irq_req}, 16'h0);
    check("R1 irq_vector", irq_vector, 16'h0180);
    bus_read(2'd0, v); check("R1 status", v, 16'h0000);
    bus_read(2'd1, v); check("R1 data", v, 16'h0000);
    bus_read(2'd2, v); check("R1 vector", v, 16'h0180);
  endtask

  task automatic t_char_read();
    logic [15:0] v;
    send_char(16'h0041);
    bus_read(2'd0, v); check("R2/R3 status done", v, 16'h8000);
    check("R7 no irq without enable", {15'd0, irq_req}, 16'h0);
    bus_read(2'd1, v); check("R2/R5 data", v, 16'h0041);
    check("R10 rdata held", bus_rdata, 16'h0041);
    bus_read(2'd0, v); check("R5 done cleared", v, 16'h0000);
  endtask

  task automatic t_status_write();
    logic [15:0] v;
    bus_write(2'd0, 16'hFFFF);
    bus_read(2'd0, v); check("R4 only ie and prio", v, 16'h4007);
    check("R7 irq_prio", {13'd0, irq_prio}, 16'h0007);
    check("R7 no irq without done", {15'd0, irq_req}, 16'h0);
    send_char(16'h005A);
    check("R7 irq raised", {15'd0, irq_req}, 16'h0001);
    bus_read(2'd0, v); check("R3 status", v, 16'hC007);
    bus_read(2'd1, v); check("R5 data", v, 16'h005A);
    check("R7 irq dropped", {15'd0, irq_req}, 16'h0);
    send_char(16'h0031);
    bus_write(2'd0, 16'h0002);
    bus_read(2'd0, v); check("R4 done kept", v, 16'h8002);
    check("R7 irq off with ie clear", {15'd0, irq_req}, 16'h0);
    check("R7 irq_prio 2", {13'd0, irq_prio}, 16'h0002);
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    send_char(16'h0032);
    bus_read(2'd0, v); check("R6 overrun set", v, 16'hA002);
    bus_read(2'd0, v); check("R6 overrun cleared by status read", v, 16'h8002);
    bus_read(2'd1, v); check("R6 data overwritten", v, 16'h0032);
    bus_read(2'd0, v); check("R5 status after read", v, 16'h0002);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    read_with_strobe(2'd1, 16'h0077, v);
    check("R5 read returns old char", v, 16'h0032);
    bus_read(2'd0, v); check("R5 strobe wins over read", v, 16'h8002);
    read_with_strobe(2'd0, 16'h0078, v);
    check("R6 status before edge", v, 16'h8002);
    bus_read(2'd0, v); check("R6 set wins over clear", v, 16'hA002);
    bus_read(2'd0, v); check("R6 cleared next", v, 16'h8002);
  endtask

  task automatic t_ignored();
    logic [15:0] v;
    bus_write(2'd1, 16'h1234);
    bus_write(2'd3, 16'hBEEF);
    bus_read(2'd3, v); check("R9 spare reads zero", v, 16'h0000);
    bus_read(2'd0, v); check("R9 status untouched", v, 16'h8002);
    bus_read(2'd2, v); check("R9 vector untouched", v, 16'h0180);
    bus_read(2'd1, v); check("R9 data untouched", v, 16'h0078);
  endtask

  task automatic t_vector();
    logic [15:0] v;
    bus_write(2'd2, 16'h00C5);
    check("R8 irq_vector", irq_vector, 16'h00C5);
    bus_read(2'd2, v); check("R8 vector read", v, 16'h00C5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_char_read();
    t_status_write();
    t_overrun();
    t_collision();
    t_ignored();
    t_vector();
    repeat (2) @(negedge clk);
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!reported) begin
      reported = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=0x0001 expected=0x0000");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end
endmodule